// File: doc/BRIEF.md
# Banked System Register Access Controller

This block holds one 32-bit configuration word that a processor reads and writes through a single request port. Each request carries a read/write flag, write data, the privilege level of the requester (0 to 3) and a secure-state bit. Side inputs supply the hypervisor trap controls, a view-select bit and two secure-write-lock pins. One cycle after a request is accepted, the block returns a response. The response carries a code (OK, UNDEFINED or hypervisor trap), a syndrome value and, for reads, the stored word.

When a secure monitor level is present and runs the 32-bit regime, the word is kept as two copies: one secure and one non-secure. Levels 1 and 2 always reach the non-secure copy. Level 3 picks the copy with its secure-state bit. When there is no such monitor, a parameter reduces storage to a single word that every legal access reaches.

The view-select bit chooses how software interprets the word. The value 1 selects the attribute view, in which byte k holds attribute entry k+4 (entry 7 sits in bits [31:24]). The value 0 selects the legacy remap view. Both views use the same storage, and decoding the attribute bytes is left to other logic.

Top module: `banked_cfg_reg`

## Requirements
- R1: A request from level 0 (req_lvl = 2'd0), read or write, answers with code UNDEFINED (2'd1) and zero data, and leaves every copy unchanged.
- R2: A level-1 request with hyp_en = 1 and trap_grp = 1 answers with code TRAP (2'd2) and syndrome 6'h03, for both reads and writes. With hyp_en = 0, or at level 2, the trap bits have no effect.
- R3: If the group trap is not taken, a level-1 request with hyp_en = 1 is trapped (code 2'd2, syndrome 6'h03) by trap_vm_rd for reads and by trap_vm_wr for writes. For each direction, the other bit has no effect.
- R4: In the banked configuration, untrapped level-1 and level-2 requests read and write the non-secure copy.
- R5: At level 3, req_ns = 0 selects the secure copy and req_ns = 1 selects the non-secure copy. A write to one copy does not change the other.
- R6: A level-3 write with req_ns = 0 answers UNDEFINED and leaves the secure copy unchanged when lock_a or lock_b is 1. Level-3 reads, and level-3 writes with req_ns = 1, are not affected by the lock pins.
- R7: The view-select bit does not change storage or read data. rsp_view returns the view-select value sampled with the request.
- R8: rsp_vld is 1 exactly in the cycle after a request is accepted (req_vld = 1 at a rising edge). rsp_code, rsp_syn, rsp_rdata and rsp_view are valid in that same cycle.
- R9: A trapped or UNDEFINED read returns zero data. A trapped or UNDEFINED write leaves both copies unchanged. Any write returns zero data, and an OK response has syndrome 0.
- R10: After reset, every copy holds the parameter RST_PAT, rsp_vld is 0 and wr_seen is 2'b00. wr_seen[0] (non-secure or single copy) and wr_seen[1] (secure copy) each become 1 after the first OK write to that copy.
- R11: With no secure monitor, or with a monitor that does not run the 32-bit regime, the single copy serves all levels 1 to 3 whatever req_ns is, the lock pins have no effect, and wr_seen[1] stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Request accepted at this edge |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| req_lvl | input | 2 | Privilege level of the requester |
| req_ns | input | 1 | Secure-state bit (1 = non-secure) |
| hyp_en | input | 1 | Hypervisor level enabled for level-1 traps |
| trap_grp | input | 1 | Per-register-group hypervisor trap |
| trap_vm_rd | input | 1 | Virtual-memory-control read trap |
| trap_vm_wr | input | 1 | Virtual-memory-control write trap |
| view_attr | input | 1 | 1 = attribute view, 0 = legacy remap view |
| lock_a | input | 1 | Secure write lock, first pin |
| lock_b | input | 1 | Secure write lock, second pin |
| rsp_vld | output | 1 | Response valid |
| rsp_code | output | 2 | 0 OK, 1 UNDEFINED, 2 TRAP |
| rsp_syn | output | 6 | Trap syndrome |
| rsp_rdata | output | 32 | Read data |
| rsp_view | output | 1 | View-select captured with the request |
| wr_seen | output | 2 | Written-since-reset flags per copy |

## Verification
The embedded properties check on every cycle that:
- a level-0 request always ends in UNDEFINED;
- a locked secure write always ends in UNDEFINED and leaves the secure copy untouched;
- no copy moves without a write;
- a failed response never carries data;
- a trap always carries syndrome 0x03;
- the response follows the request by exactly one cycle.

Some behaviours can only be shown by the bench's ordered scenarios, because they depend on the history of stored values across requests:
- the priority between the group trap and the read/write-specific trap bits;
- which copy each level and secure-state combination reaches;
- the same word being read back through both views;
- the single-copy configuration on a second instance.

// File: rtl/banked_cfg_reg.sv
module banked_cfg_reg #(
  parameter int DW = 32,
  parameter int SYN_W = 6,
  parameter logic [SYN_W-1:0] TRAP_SYN = 6'h03,
  parameter logic [DW-1:0] RST_PAT = '0,
  parameter bit MON_PRESENT = 1'b1,
  parameter bit MON_NARROW = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_vld,
  input  logic             req_wr,
  input  logic [DW-1:0]    req_wdata,
  input  logic [1:0]       req_lvl,
  input  logic             req_ns,
  input  logic             hyp_en,
  input  logic             trap_grp,
  input  logic             trap_vm_rd,
  input  logic             trap_vm_wr,
  input  logic             view_attr,
  input  logic             lock_a,
  input  logic             lock_b,
  output logic             rsp_vld,
  output logic [1:0]       rsp_code,
  output logic [SYN_W-1:0] rsp_syn,
  output logic [DW-1:0]    rsp_rdata,
  output logic             rsp_view,
  output logic [1:0]       wr_seen
);
  localparam bit BANKED = MON_PRESENT && MON_NARROW;
  localparam logic [1:0] C_OK = 2'd0, C_UND = 2'd1, C_TRAP = 2'd2;

  logic [DW-1:0] ns_q, sec_q, cur;
  logic ns_seen, sec_seen;
  logic sec_sel, trap_hit, undef_hit, acc_ok, do_wr;
  logic [1:0] code;

  assign sec_sel   = BANKED && (req_lvl == 2'd3) && !req_ns;
  assign trap_hit  = (req_lvl == 2'd1) && hyp_en &&
                     (trap_grp || (req_wr ? trap_vm_wr : trap_vm_rd));
  assign undef_hit = (req_lvl == 2'd0) || (sec_sel && req_wr && (lock_a || lock_b));
  assign code      = undef_hit ? C_UND : (trap_hit ? C_TRAP : C_OK);
  assign acc_ok    = req_vld && (code == C_OK);
  assign do_wr     = acc_ok && req_wr;
  assign cur       = sec_sel ? sec_q : ns_q;
  assign wr_seen   = {sec_seen, ns_seen};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ns_q <= RST_PAT;
      ns_seen <= 1'b0;
    end else if (do_wr && !sec_sel) begin
      ns_q <= req_wdata;
      ns_seen <= 1'b1;
    end
  end

  generate
    if (BANKED) begin : g_sec
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          sec_q <= RST_PAT;
          sec_seen <= 1'b0;
        end else if (do_wr && sec_sel) begin
          sec_q <= req_wdata;
          sec_seen <= 1'b1;
        end
      end
    end else begin : g_nosec
      assign sec_q = RST_PAT;
      assign sec_seen = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_vld   <= 1'b0;
      rsp_code  <= C_OK;
      rsp_syn   <= '0;
      rsp_rdata <= '0;
      rsp_view  <= 1'b0;
    end else begin
      rsp_vld <= req_vld;
      if (req_vld) begin
        rsp_code  <= code;
        rsp_syn   <= (code == C_TRAP) ? TRAP_SYN : '0;
        rsp_rdata <= (acc_ok && !req_wr) ? cur : '0;
        rsp_view  <= view_attr;
      end
    end
  end

  // R1
  lvl0_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld && req_lvl == 2'd0 |=> rsp_vld && rsp_code == C_UND);
  // R6
  sec_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld && req_wr && sec_sel && (lock_a || lock_b) |=> rsp_code == C_UND && $stable(sec_q));
  // R9
  no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_vld && req_wr) |=> $stable(ns_q) && $stable(sec_q));
  // R9
  fail_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld && rsp_code != C_OK |-> rsp_rdata == '0);
  // R2
  trap_syn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld && rsp_code == C_TRAP |-> rsp_syn == TRAP_SYN);
  // R8
  rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> rsp_vld);
  // R8
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> !rsp_vld);
endmodule

// File: tb/sim_banked_cfg_reg.sv
module sim_banked_cfg_reg;
  localparam int PERIOD = 10;
  localparam logic [31:0] PAT1 = 32'hC0DE_0000;

  logic clk = 0, rst_n = 0;
  logic v0 = 0, v1 = 0, wr = 0, ns = 0, hyp = 0, tg = 0, tr = 0, tw = 0;
  logic vw = 0, la = 0, lb = 0;
  logic [1:0] lvl = 0;
  logic [31:0] wd = 0;
  logic rv0, rv1, vo0, vo1;
  logic [1:0] rc0, rc1, ws0, ws1;
  logic [5:0] rs0, rs1;
  logic [31:0] rd0, rd1;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  banked_cfg_reg u0 (.clk, .rst_n, .req_vld(v0), .req_wr(wr), .req_wdata(wd), .req_lvl(lvl),
    .req_ns(ns), .hyp_en(hyp), .trap_grp(tg), .trap_vm_rd(tr), .trap_vm_wr(tw), .view_attr(vw),
    .lock_a(la), .lock_b(lb), .rsp_vld(rv0), .rsp_code(rc0), .rsp_syn(rs0), .rsp_rdata(rd0),
    .rsp_view(vo0), .wr_seen(ws0));

  banked_cfg_reg #(.RST_PAT(PAT1), .MON_PRESENT(1'b0)) u1 (.clk, .rst_n, .req_vld(v1),
    .req_wr(wr), .req_wdata(wd), .req_lvl(lvl), .req_ns(ns), .hyp_en(hyp), .trap_grp(tg),
    .trap_vm_rd(tr), .trap_vm_wr(tw), .view_attr(vw), .lock_a(la), .lock_b(lb), .rsp_vld(rv1),
    .rsp_code(rc1), .rsp_syn(rs1), .rsp_rdata(rd1), .rsp_view(vo1), .wr_seen(ws1));

  // {req[3:0], wr, lvl[1:0], ns, hyp, tg, tr, tw, la, lb, vw, wdata[31:0], code[1:0], rdata[31:0]}
  localparam int NV = 25;
  localparam logic [80:0] VEC [NV] = '{
    {4'd10,1'b0,2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,2'd0,32'h0},          // R10 reset value
    {4'd4, 1'b1,2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,32'hA5A5_0001,2'd0,32'h0},  // R4 L1 write
    {4'd4, 1'b0,2'd2,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,2'd0,32'hA5A5_0001},  // R4 L2 read
    {4'd5, 1'b0,2'd3,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,2'd0,32'hA5A5_0001},  // R5 ns copy
    {4'd5, 1'b0,2'd3,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,2'd0,32'h0},          // R5 sec untouched
    {4'd5, 1'b1,2'd3,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,32'h5EC0_0002,2'd0,32'h0},  // R5 sec write
    {4'd5, 1'b0,2'd3,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,2'd0,32'h5EC0_0002},  // R5 sec read
    {4'd4, 1'b0,2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,2'd0,32'hA5A5_0001},  // R4 ns intact
    {4'd1, 1'b1,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,32'hFFFF_FFFF,2'd1,32'h0},  // R1 L0 write
    {4'd1, 1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,2'd1,32'h0},          // R1 L0 read
    {4'd2, 1'b1,2'd1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,32'h1111_1111,2'd2,32'h0},  // R2 grp wr
    {4'd2, 1'b0,2'd1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,2'd2,32'h0},          // R2 grp rd
    {4'd3, 1'b0,2'd1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,32'h0,2'd2,32'h0},          // R3 rd trap
    {4'd3, 1'b0,2'd1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,32'h0,2'd0,32'hA5A5_0001},  // R3 wr bit on read
    {4'd3, 1'b1,2'd1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,32'h2222_2222,2'd2,32'h0},  // R3 wr trap
    {4'd3, 1'b1,2'd1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,32'h0000_1234,2'd0,32'h0},  // R3 rd bit on write
    {4'd2, 1'b0,2'd1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,32'h0,2'd0,32'h0000_1234},  // R2 hyp off
    {4'd2, 1'b0,2'd2,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,32'h0,2'd0,32'h0000_1234},  // R2 L2 no trap
    {4'd6, 1'b1,2'd3,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,32'h3333_3333,2'd1,32'h0},  // R6 lock_a
    {4'd6, 1'b1,2'd3,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,32'h4444_4444,2'd1,32'h0},  // R6 lock_b
    {4'd6, 1'b0,2'd3,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,32'h0,2'd0,32'h5EC0_0002},  // R6 read ok
    {4'd6, 1'b1,2'd3,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,32'h0BAD_F00D,2'd0,32'h0},  // R6 ns write ok
    {4'd7, 1'b0,2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,2'd0,32'h0BAD_F00D},  // R7 view 0
    {4'd7, 1'b0,2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,32'h0,2'd0,32'h0BAD_F00D},  // R7 view 1
    {4'd9, 1'b0,2'd3,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,2'd0,32'h5EC0_0002}   // R9 sec kept
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic req(input bit use1, input logic w, input logic [1:0] l, input logic n,
                     input logic [31:0] d);
    @(negedge clk);
    wr = w; lvl = l; ns = n; wd = d;
    if (use1) v1 = 1; else v0 = 1;
    @(negedge clk);
    v0 = 0; v1 = 0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 rsp_vld after reset", {63'd0, rv0}, 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R10 wr_seen after reset", {62'd0, ws0}, 64'd0);
    chk("R8 idle no response", {63'd0, rv0}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      logic [80:0] v;
      v = VEC[i];
      hyp = v[72]; tg = v[71]; tr = v[70]; tw = v[69]; la = v[68]; lb = v[67]; vw = v[66];
      req(0, v[76], v[75:74], v[73], v[65:34]);
      chk($sformatf("R%0d vec%0d code", v[80:77], i), {62'd0, rc0}, {62'd0, v[33:32]});
      chk($sformatf("R%0d vec%0d data", v[80:77], i), {32'd0, rd0}, {32'd0, v[31:0]});
      chk($sformatf("R%0d vec%0d syn", v[80:77], i), {58'd0, rs0},
          (v[33:32] == 2'd2) ? 64'd3 : 64'd0);
      chk($sformatf("R7 vec%0d view echo", i), {63'd0, vo0}, {63'd0, vw});
      chk($sformatf("R8 vec%0d rsp_vld", i), {63'd0, rv0}, 64'd1);
    end
    hyp = 0; tg = 0; tr = 0; tw = 0; la = 0; lb = 0; vw = 0;
    @(negedge clk);
    chk("R8 rsp_vld drops", {63'd0, rv0}, 64'd0);
    chk("R10 wr_seen both copies", {62'd0, ws0}, 64'd3);

    // R11 single-copy instance
    req(1, 0, 2'd2, 0, 0);
    chk("R11 reset pattern", {32'd0, rd1}, {32'd0, PAT1});
    la = 1; lb = 1;
    req(1, 1, 2'd3, 0, 32'h600D_0003);
    chk("R11 lock ignored", {62'd0, rc1}, 64'd0);
    la = 0; lb = 0;
    req(1, 0, 2'd1, 0, 0);
    chk("R11 L1 sees L3 write", {32'd0, rd1}, 64'h600D_0003);
    req(1, 0, 2'd3, 1, 0);
    chk("R11 ns bit ignored", {32'd0, rd1}, 64'h600D_0003);
    chk("R11 wr_seen secure stays 0", {62'd0, ws1}, 64'd1);
    finish_run();
  end
endmodule